// File: doc/BRIEF.md
# Execution Hash Integrity Checker

This block watches a stream of retired instructions and bus transfers from a processor and folds them into three running 32-bit CRC signatures. One covers instruction words, one covers addresses and one covers bus data. A lockstep replica of the same processor keeps the same signatures. When the two executions agree, the signatures agree, and the captured trace can be trusted. The block is a passive observer. It has no output that feeds back into the monitored system.

A snapshot input freezes all three signatures in one cycle. A remote signature that arrives with a strobe is then compared against the frozen copy chosen by a select input. Any disagreement raises a sticky mismatch flag. The block also keeps one written bit per word of a 256-word local RAM. A read from a RAM word that has never been written raises a sticky uninitialized-read flag and records the address of that first read.

Top module: `exec_hash_checker`

## Requirements
- R1: After synchronous reset, all three live signatures read 0xFFFFFFFF, `mismatch` and `uninit_rd` are 0, and `uninit_addr` is 0.
- R2: Each signature update is a non-reflected CRC-32 step with polynomial 0x04C11DB7 and no final XOR. The step takes the 32-bit word MSB first, and only one step is taken per accepted transfer.
- R3: A valid transfer of kind 0 (instruction retire) steps the instruction signature with `xfer_data` and the address signature with `xfer_addr`. The data signature is left unchanged.
- R4: A valid transfer of kind 1 (read) or kind 2 (write) steps the address signature with `xfer_addr` and the data signature with `xfer_data`. The instruction signature is left unchanged.
- R5: Kind 3 transfers, and cycles with `xfer_valid` low, change no signature and no RAM tracking state.
- R6: An address lies in the RAM window when bits 31:10 equal 0x2000_0000 bits 31:10. Within the window, bits 9:2 select the word. A write to a window address marks that word as written, and later reads of that word raise no flag.
- R7: A read of a window word that has not been written since reset sets `uninit_rd`, which stays set until reset. That first offending read also loads its address into `uninit_addr`. Later offending reads leave `uninit_addr` unchanged.
- R8: Reads outside the RAM window never set `uninit_rd`.
- R9: When `snap` is high, all three snapshot copies capture the live signatures as they stood before that cycle's transfer.
- R10: When `remote_vld` is high, `remote_sig` is compared with the snapshot chosen by `sel`: 0 selects instruction, 1 address, 2 data, and 3 the XOR of all three. If they differ, `mismatch` is 1 from the next cycle. If they are equal, `mismatch` is left as it was.
- R11: Once set, `mismatch` stays set through any later traffic, snapshots or matching compares, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Transfer present this cycle |
| xfer_kind | input | 2 | 0 instruction, 1 read, 2 write, 3 ignored |
| xfer_addr | input | 32 | Program counter or bus address |
| xfer_data | input | 32 | Instruction word or bus data |
| snap | input | 1 | Freeze the signatures into the snapshot copies |
| remote_vld | input | 1 | Remote signature strobe |
| sel | input | 2 | Snapshot to compare against |
| remote_sig | input | 32 | Signature from the replica |
| sig_instr | output | 32 | Live instruction signature |
| sig_addr | output | 32 | Live address signature |
| sig_data | output | 32 | Live data signature |
| mismatch | output | 1 | Sticky integrity error |
| uninit_rd | output | 1 | Sticky uninitialized-read flag |
| uninit_addr | output | 32 | Address of the first uninitialized read |

## Verification
A fault in the CRC step or in lane routing shows on the live signature outputs in the cycle after the faulty transfer. Every later transfer carries the error forward, so a single wrong step is never hidden. A written-bit that is wrongly cleared or wrongly set shows in `uninit_rd` and `uninit_addr` one cycle after the next read of that word. A corrupt snapshot copy shows only indirectly: `mismatch` is set, or fails to be set, one cycle after a compare that uses that copy.

// File: rtl/hashchk_pkg.sv
package hashchk_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam int unsigned N_LANES  = 3;

    typedef enum logic [1:0] {
        K_INSTR = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_NONE  = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        S_INSTR = 2'd0,
        S_ADDR  = 2'd1,
        S_DATA  = 2'd2,
        S_FOLD  = 2'd3
    } sig_sel_e;

    typedef struct packed {
        logic              vld;
        xfer_kind_e        kind;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } xfer_t;

    function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] c,
                                                   input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] r;
        logic fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[WORD_W-1] ^ d[i];
            r  = {r[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction
endpackage

// File: rtl/hash_lane.sv
module hash_lane
    import hashchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] sig
);
    always_ff @(posedge clk) begin
        if (rst)     sig <= CRC_SEED;
        else if (en) sig <= crc_step(sig, din);
    end

    // R5: a lane that is not enabled holds its signature
    p_lane_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sig));
endmodule

// File: rtl/ram_init_tracker.sv
module ram_init_tracker
    import hashchk_pkg::*;
#(
    parameter int unsigned RAM_WORDS = 256,
    parameter logic [WORD_W-1:0] RAM_BASE = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             x,
    output logic              uninit_rd,
    output logic [WORD_W-1:0] uninit_addr
);
    localparam int unsigned IDX_W = $clog2(RAM_WORDS);
    localparam int unsigned TOP_L = IDX_W + 2;

    logic [RAM_WORDS-1:0] written;
    logic [IDX_W-1:0]     idx;
    logic                 in_win, is_rd, is_wr, bad_rd;

    assign idx    = x.addr[TOP_L-1:2];
    assign in_win = (x.addr[WORD_W-1:TOP_L] == RAM_BASE[WORD_W-1:TOP_L]);
    assign is_rd  = x.vld && (x.kind == K_READ)  && in_win;
    assign is_wr  = x.vld && (x.kind == K_WRITE) && in_win;
    assign bad_rd = is_rd && !written[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            written     <= '0;
            uninit_rd   <= 1'b0;
            uninit_addr <= '0;
        end else begin
            if (is_wr) written[idx] <= 1'b1;
            if (bad_rd) begin
                uninit_rd <= 1'b1;
                if (!uninit_rd) uninit_addr <= x.addr;
            end
        end
    end

    // R7: flag is sticky and the recorded address is frozen once set
    p_uninit_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        uninit_rd |=> uninit_rd);
    p_uninit_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        uninit_rd |=> $stable(uninit_addr));
    // R6: a written word never loses its mark
    p_written_monotone_r6: assert property (@(posedge clk) disable iff (rst)
        (written & ~$past(written)) == (written ^ $past(written)));
endmodule

// File: rtl/sig_compare.sv
module sig_compare
    import hashchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snap,
    input  logic [WORD_W-1:0] live [N_LANES],
    input  logic              remote_vld,
    input  sig_sel_e          sel,
    input  logic [WORD_W-1:0] remote_sig,
    output logic              mismatch
);
    logic [WORD_W-1:0] held [N_LANES];
    logic [WORD_W-1:0] pick;

    for (genvar g = 0; g < N_LANES; g++) begin : g_snap
        always_ff @(posedge clk) begin
            if (rst)       held[g] <= CRC_SEED;
            else if (snap) held[g] <= live[g];
        end
        // R9: snapshot copies move only on a snap request
        p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
            !snap |=> $stable(held[g]));
    end

    always_comb begin
        unique case (sel)
            S_INSTR: pick = held[0];
            S_ADDR:  pick = held[1];
            S_DATA:  pick = held[2];
            default: pick = held[0] ^ held[1] ^ held[2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                                  mismatch <= 1'b0;
        else if (remote_vld && pick != remote_sig) mismatch <= 1'b1;
    end

    // R11: error is sticky until reset
    p_mismatch_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> mismatch);
    // R10: error rises only after a strobe
    p_mismatch_cause_r10: assert property (@(posedge clk) disable iff (rst)
        !mismatch && !remote_vld |=> !mismatch);
endmodule

// File: rtl/exec_hash_checker.sv
module exec_hash_checker
    import hashchk_pkg::*;
#(
    parameter int unsigned RAM_WORDS = 256,
    parameter logic [31:0] RAM_BASE  = 32'h2000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_valid,
    input  logic [1:0]  xfer_kind,
    input  logic [31:0] xfer_addr,
    input  logic [31:0] xfer_data,
    input  logic        snap,
    input  logic        remote_vld,
    input  logic [1:0]  sel,
    input  logic [31:0] remote_sig,
    output logic [31:0] sig_instr,
    output logic [31:0] sig_addr,
    output logic [31:0] sig_data,
    output logic        mismatch,
    output logic        uninit_rd,
    output logic [31:0] uninit_addr
);
    xfer_t             x;
    logic              lane_en  [N_LANES];
    logic [WORD_W-1:0] lane_din [N_LANES];
    logic [WORD_W-1:0] lane_sig [N_LANES];

    assign x.vld  = xfer_valid;
    assign x.kind = xfer_kind_e'(xfer_kind);
    assign x.addr = xfer_addr;
    assign x.data = xfer_data;

    always_comb begin
        lane_en[0]  = x.vld && (x.kind == K_INSTR);
        lane_en[1]  = x.vld && (x.kind != K_NONE);
        lane_en[2]  = x.vld && (x.kind == K_READ || x.kind == K_WRITE);
        lane_din[0] = x.data;
        lane_din[1] = x.addr;
        lane_din[2] = x.data;
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        hash_lane u_lane (
            .clk (clk),
            .rst (rst),
            .en  (lane_en[g]),
            .din (lane_din[g]),
            .sig (lane_sig[g])
        );
    end

    assign sig_instr = lane_sig[0];
    assign sig_addr  = lane_sig[1];
    assign sig_data  = lane_sig[2];

    ram_init_tracker #(.RAM_WORDS(RAM_WORDS), .RAM_BASE(RAM_BASE)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .x           (x),
        .uninit_rd   (uninit_rd),
        .uninit_addr (uninit_addr)
    );

    sig_compare u_cmp (
        .clk        (clk),
        .rst        (rst),
        .snap       (snap),
        .live       (lane_sig),
        .remote_vld (remote_vld),
        .sel        (sig_sel_e'(sel)),
        .remote_sig (remote_sig),
        .mismatch   (mismatch)
    );

    // R3: an instruction retire never moves the data signature
    p_instr_keeps_data_r3: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && xfer_kind == 2'd0 |=> $stable(sig_data));
    // R4: a bus transfer never moves the instruction signature
    p_bus_keeps_instr_r4: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && (xfer_kind == 2'd1 || xfer_kind == 2'd2) |=> $stable(sig_instr));
    // R8: reads outside the window never raise the flag
    p_outside_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !uninit_rd && xfer_valid && xfer_addr[31:10] != RAM_BASE[31:10] |=> !uninit_rd);
endmodule

// File: tb/tb_exec_hash_checker.sv
module tb_exec_hash_checker;
    logic        clk = 1'b0;
    logic        rst;
    logic        xfer_valid = 1'b0;
    logic [1:0]  xfer_kind = 2'd0;
    logic [31:0] xfer_addr = '0, xfer_data = '0;
    logic        snap = 1'b0, remote_vld = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [31:0] remote_sig = '0;
    logic [31:0] sig_instr, sig_addr, sig_data, uninit_addr;
    logic        mismatch, uninit_rd;

    int total = 0, bad = 0;
    logic [31:0] m_i, m_a, m_d, s_i, s_a, s_d;

    always #10 clk = ~clk;

    exec_hash_checker dut (.*);

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        r = c ^ d;
        for (int k = 0; k < 32; k++)
            r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_sigs(input string req);
        chk(req, sig_instr, m_i);
        chk(req, sig_addr, m_a);
        chk(req, sig_data, m_d);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_i = 32'hFFFFFFFF; m_a = m_i; m_d = m_i; s_i = m_i; s_a = m_i; s_d = m_i;
    endtask

    task automatic xfer(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d,
                        input logic v = 1'b1);
        xfer_valid = v; xfer_kind = k; xfer_addr = a; xfer_data = d;
        @(negedge clk);
        xfer_valid = 1'b0;
        if (v && k == 2'd0) begin m_i = ref_crc(m_i, d); m_a = ref_crc(m_a, a); end
        if (v && (k == 2'd1 || k == 2'd2)) begin m_a = ref_crc(m_a, a); m_d = ref_crc(m_d, d); end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", sig_instr, 32'hFFFFFFFF);
        chk("R1", sig_addr, 32'hFFFFFFFF);
        chk("R1", sig_data, 32'hFFFFFFFF);
        chk("R1", {mismatch, uninit_rd}, 0);
        chk("R1", uninit_addr, 0);
    endtask

    task automatic t_crc();
        // R2: known value for a zero word from seed
        xfer(2'd0, 32'h0, 32'h0);
        chk("R2", sig_instr, ref_crc(32'hFFFFFFFF, 32'h0));
        chk("R2", sig_instr, 32'hC704DD7B);
        // R3
        xfer(2'd0, 32'h0000_0104, 32'hE3A0_1005);
        chk_sigs("R3");
        // R4
        xfer(2'd1, 32'h4000_0010, 32'h1234_5678);
        xfer(2'd2, 32'h2000_0020, 32'hCAFE_F00D);
        chk_sigs("R4");
    endtask

    task automatic t_ignore();
        xfer(2'd3, 32'h2000_0040, 32'hDEAD_BEEF);
        xfer(2'd1, 32'h2000_0044, 32'h1111_1111, 1'b0);
        chk_sigs("R5");
        chk("R5", uninit_rd, 1'b0);
    endtask

    task automatic t_ram();
        xfer(2'd2, 32'h2000_0300, 32'h5);
        xfer(2'd1, 32'h2000_0300, 32'h5);
        chk("R6", uninit_rd, 1'b0);
        xfer(2'd1, 32'h2000_0020, 32'h0); // written in t_crc
        chk("R6", uninit_rd, 1'b0);
        xfer(2'd1, 32'h4000_0400, 32'h0);
        xfer(2'd1, 32'h1FFF_FFFC, 32'h0);
        chk("R8", uninit_rd, 1'b0);
        xfer(2'd1, 32'h2000_03FC, 32'h0);
        chk("R7", uninit_rd, 1'b1);
        chk("R7", uninit_addr, 32'h2000_03FC);
        xfer(2'd1, 32'h2000_0008, 32'h0);
        chk("R7", uninit_rd, 1'b1);
        chk("R7", uninit_addr, 32'h2000_03FC);
        chk_sigs("R4");
    endtask

    task automatic t_cmp();
        snap = 1'b1;
        s_i = m_i; s_a = m_a; s_d = m_d;
        xfer(2'd0, 32'h0000_0200, 32'h0BAD_C0DE); // transfer in snap cycle
        snap = 1'b0;
        chk_sigs("R9");
        remote_vld = 1'b1;
        sel = 2'd0; remote_sig = s_i; @(negedge clk);
        sel = 2'd1; remote_sig = s_a; @(negedge clk);
        sel = 2'd2; remote_sig = s_d; @(negedge clk);
        sel = 2'd3; remote_sig = s_i ^ s_a ^ s_d; @(negedge clk);
        remote_vld = 1'b0;
        chk("R9", mismatch, 1'b0);
        chk("R10", mismatch, 1'b0);
        remote_vld = 1'b1; sel = 2'd2; remote_sig = s_d ^ 32'h1; @(negedge clk);
        remote_vld = 1'b0;
        chk("R10", mismatch, 1'b1);
        xfer(2'd0, 32'h4, 32'h8);
        snap = 1'b1; @(negedge clk); snap = 1'b0;
        remote_vld = 1'b1; sel = 2'd0; remote_sig = m_i; @(negedge clk);
        remote_vld = 1'b0;
        chk("R11", mismatch, 1'b1);
        do_reset();
        chk("R11", mismatch, 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_crc();
        t_ignore();
        t_ram();
        t_cmp();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule